// File: doc/BRIEF.md
# Secure Access Filter

This block sits on the path between a processor's memory request port and the memory system. It checks every request against a small table of address regions and decides whether the request may go through. Each region is either secure or non-secure and can also be marked execute-only. A request carries the security state of the core and says whether it is an instruction fetch or a data read or write. A permitted request is passed downstream unchanged. A refused request never reaches memory. Instead it completes with zero data and a one-cycle fault pulse that carries a reason code.

The same filter watches stack-pointer updates. It keeps one lower bound for each security state and flags any stack pointer that drops below the bound of the current state. Secure software programs the region table and the two bounds through a small register write port. A non-secure attempt to program them changes nothing and is reported as a security violation.

Control is one state machine with five states:
- `S_IDLE` takes one event per cycle.
- `S_ISSUE` holds the forwarded request until the downstream side acknowledges it.
- `S_RESP` returns the response.
- `S_DENY` completes a refused request.
- `S_ALERT` emits a fault that has no response attached.

The transitions are:
- IDLE→ALERT: non-secure register write, or stack violation.
- IDLE→DENY: refused request.
- IDLE→ISSUE: permitted request.
- ISSUE→RESP: on acknowledge.
- RESP, DENY and ALERT return to IDLE after one cycle.

Top module: `sec_access_filter`

## Requirements
- R1: After reset, `up_ready` is high and `up_rvalid`, `dn_valid`, `fault_valid` and `dn_wstrb` are all zero. No region is enabled and both stack bounds are zero.
- R2: An address that hits no enabled region is treated as secure. A non-secure request to it is refused with fault code 1, and a secure request to it is permitted.
- R3: A non-secure request, read or write, that hits a secure region is refused with fault code 1. `dn_valid` stays low and `dn_wstrb` stays zero, so memory is left untouched.
- R4: A secure request may reach secure and non-secure regions, and a non-secure request may reach non-secure regions. A permitted request appears on `dn_*` in the cycle after acceptance, with address, fetch flag, write flag, data and strobes unchanged. `dn_wstrb` is zero for reads. The response comes in the cycle after the edge that samples `dn_ack`. It carries the read data for a read and zero for a write.
- R5: A region with the execute-only attribute passes instruction fetches. It refuses data reads and data writes with fault code 2. The security check has precedence, so a non-secure fetch to a secure execute-only region gets code 1.
- R6: When enabled regions overlap, the region with the lowest index decides the attributes.
- R7: A refused request completes in the cycle after acceptance. In that cycle `up_rvalid` is high, `up_rdata` is zero and `fault_valid` is high for exactly one cycle.
- R8: The configuration port works as follows:
  - A write is accepted only while `core_secure` is high.
  - With `cfg_addr[5]` = 0, the address selects region `cfg_addr[4:2]` and field `cfg_addr[1:0]`.
  - Field 0 sets the base granule from `cfg_wdata[31:5]`, and field 1 sets the inclusive limit granule from the same bits.
  - Field 2 sets the attributes: bit 0 enable, bit 1 secure, bit 2 execute-only.
  - With `cfg_addr[5]` = 1, `cfg_addr[0]` selects the secure (0) or non-secure (1) stack bound.
  - A non-secure write changes nothing and gives a fault with code 1 one cycle later.
- R9: A `sp_value` strictly below the bound of the state given by `core_secure` gives a fault with code 3 one cycle later. A value equal to or above the bound gives no fault.
- R10: `cfg_we`, `sp_valid` and `up_valid` are taken only while `up_ready` is high, and only one per cycle. The order of precedence is configuration write, then stack check, then request, and a request waits while a higher-precedence event is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| core_secure | input | 1 | Core security state for the current event (1 = secure) |
| up_valid | input | 1 | Request present |
| up_ready | output | 1 | Filter idle and able to take one event |
| up_addr | input | 32 | Request byte address |
| up_write | input | 1 | 1 = data write |
| up_fetch | input | 1 | 1 = instruction fetch |
| up_wdata | input | 32 | Write data |
| up_wstrb | input | 4 | Write byte strobes |
| up_rvalid | output | 1 | Request completion |
| up_rdata | output | 32 | Read data, zero on refusal or write |
| dn_valid | output | 1 | Forwarded request, held until acknowledged |
| dn_addr | output | 32 | Forwarded address |
| dn_write | output | 1 | Forwarded write flag |
| dn_fetch | output | 1 | Forwarded fetch flag |
| dn_wdata | output | 32 | Forwarded write data |
| dn_wstrb | output | 4 | Forwarded strobes, zero unless forwarding a write |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, valid with `dn_ack` |
| cfg_we | input | 1 | Configuration write |
| cfg_addr | input | 6 | Configuration register select |
| cfg_wdata | input | 32 | Configuration data |
| sp_valid | input | 1 | Stack pointer update present |
| sp_value | input | 32 | New stack pointer value |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | 1 security, 2 execute-only data access, 3 stack bound |

## Verification
Each event taken at a rising edge has a fixed due cycle:
- A refused request and a fault with no response are visible in the very next cycle.
- A permitted request shows on `dn_*` in the next cycle.
- With an acknowledge one cycle after `dn_valid`, the response arrives three cycles after acceptance.

The driver samples on falling edges and counts exactly those edges after the accepting rising edge before it checks the forwarded fields, the refusal or the response strobe. A scoreboard queue additionally checks that every response and fault pulse arrives in order with the predicted data and code. Any output with no pending expectation counts as a miscompare.

// File: rtl/saf_pkg.sv
`timescale 1ns/1ps
package saf_pkg;

    // Control states of the filter
    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_RESP,
        S_DENY,
        S_ALERT
    } saf_state_e;

    // Fault reason codes seen on fault_code
    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_SECURITY = 2'd1,
        FLT_XONLY    = 2'd2,
        FLT_STACK    = 2'd3
    } saf_fault_e;

    // Configuration field selectors inside a region slot
    localparam logic [1:0] FLD_BASE  = 2'd0;
    localparam logic [1:0] FLD_LIMIT = 2'd1;
    localparam logic [1:0] FLD_ATTR  = 2'd2;

    // Attribute bit positions in field 2
    localparam int ATTR_EN  = 0;
    localparam int ATTR_SEC = 1;
    localparam int ATTR_XO  = 2;

    // Attributes resolved for one looked-up address
    typedef struct packed {
        logic secure;
        logic xonly;
    } saf_match_t;

endpackage

// File: rtl/saf_region_table.sv
`timescale 1ns/1ps
module saf_region_table
    import saf_pkg::*;
#(
    parameter int NREG = 8,
    parameter int GW   = 27
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [1:0]               wr_field,
    input  logic [GW-1:0]            wr_gran,
    input  logic [2:0]               wr_attr,
    input  logic [GW-1:0]            lk_gran,
    output saf_match_t               lk_res
);
    localparam int IDX_W = $clog2(NREG);

    logic [GW-1:0] base_q [NREG];
    logic [GW-1:0] lim_q  [NREG];
    logic [NREG-1:0] en_q, sec_q, xo_q;
    logic [NREG-1:0] hit_vec;

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                lim_q[i]  <= '0;
                en_q[i]   <= 1'b0;
                sec_q[i]  <= 1'b0;
                xo_q[i]   <= 1'b0;
            end else if (sel) begin
                if (wr_field == FLD_BASE)  base_q[i] <= wr_gran;
                if (wr_field == FLD_LIMIT) lim_q[i]  <= wr_gran;
                if (wr_field == FLD_ATTR) begin
                    en_q[i]  <= wr_attr[ATTR_EN];
                    sec_q[i] <= wr_attr[ATTR_SEC];
                    xo_q[i]  <= wr_attr[ATTR_XO];
                end
            end
        end

        assign hit_vec[i] = en_q[i] && (lk_gran >= base_q[i]) && (lk_gran <= lim_q[i]);
    end

    // Lowest index wins: scan from the top so lower slots overwrite
    always_comb begin
        lk_res.secure = 1'b1;
        lk_res.xonly  = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                lk_res.secure = sec_q[i];
                lk_res.xonly  = xo_q[i];
            end
        end
    end

endmodule

// File: rtl/saf_policy.sv
`timescale 1ns/1ps
module saf_policy
    import saf_pkg::*;
(
    input  logic       core_secure,
    input  logic       fetch,
    input  saf_match_t attrs,
    output logic       deny,
    output saf_fault_e code
);
    always_comb begin
        deny = 1'b0;
        code = FLT_NONE;
        if (!core_secure && attrs.secure) begin
            deny = 1'b1;
            code = FLT_SECURITY;
        end else if (attrs.xonly && !fetch) begin
            deny = 1'b1;
            code = FLT_XONLY;
        end
    end
endmodule

// File: rtl/saf_stack_guard.sv
`timescale 1ns/1ps
module saf_stack_guard #(
    parameter int AW = 32
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_nonsec,
    input  logic [AW-1:0] wr_data,
    input  logic          chk_secure,
    input  logic [AW-1:0] chk_value,
    output logic          violation
);
    localparam int NSTATE = 2;

    logic [NSTATE-1:0][AW-1:0] lim_q;

    for (genvar s = 0; s < NSTATE; s++) begin : g_bound
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lim_q[s] <= '0;
            else if (wr_en && (wr_nonsec == s[0]))
                lim_q[s] <= wr_data;
        end
    end

    assign violation = chk_value < (chk_secure ? lim_q[0] : lim_q[1]);
endmodule

// File: rtl/sec_access_filter.sv
`timescale 1ns/1ps
module sec_access_filter
    import saf_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int NREG     = 8,
    parameter int GRAN_LSB = 5
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     core_secure,
    input  logic                     up_valid,
    output logic                     up_ready,
    input  logic [AW-1:0]            up_addr,
    input  logic                     up_write,
    input  logic                     up_fetch,
    input  logic [DW-1:0]            up_wdata,
    input  logic [DW/8-1:0]          up_wstrb,
    output logic                     up_rvalid,
    output logic [DW-1:0]            up_rdata,
    output logic                     dn_valid,
    output logic [AW-1:0]            dn_addr,
    output logic                     dn_write,
    output logic                     dn_fetch,
    output logic [DW-1:0]            dn_wdata,
    output logic [DW/8-1:0]          dn_wstrb,
    input  logic                     dn_ack,
    input  logic [DW-1:0]            dn_rdata,
    input  logic                     cfg_we,
    input  logic [$clog2(NREG)+2:0]  cfg_addr,
    input  logic [AW-1:0]            cfg_wdata,
    input  logic                     sp_valid,
    input  logic [AW-1:0]            sp_value,
    output logic                     fault_valid,
    output logic [1:0]               fault_code
);
    localparam int STRB_W = DW / 8;
    localparam int IDX_W  = $clog2(NREG);
    localparam int CFG_AW = IDX_W + 3;
    localparam int GW     = AW - GRAN_LSB;

    saf_state_e state_q, state_d;
    saf_fault_e code_q, code_d;

    logic [AW-1:0]     req_addr_q;
    logic              req_write_q;
    logic              req_fetch_q;
    logic [DW-1:0]     req_wdata_q;
    logic [STRB_W-1:0] req_wstrb_q;
    logic [DW-1:0]     rdata_q;

    logic       idle;
    logic       cfg_is_stack;
    logic       tbl_we, stk_we;
    logic       req_take;
    saf_match_t attrs;
    logic       pol_deny;
    saf_fault_e pol_code;
    logic       sp_viol;

    assign idle         = (state_q == S_IDLE);
    assign cfg_is_stack = cfg_addr[CFG_AW-1];
    assign tbl_we       = idle && cfg_we && core_secure && !cfg_is_stack;
    assign stk_we       = idle && cfg_we && core_secure && cfg_is_stack;
    assign req_take     = idle && !cfg_we && !sp_valid && up_valid;

    saf_region_table #(
        .NREG (NREG),
        .GW   (GW)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (cfg_addr[IDX_W+1:2]),
        .wr_field (cfg_addr[1:0]),
        .wr_gran  (cfg_wdata[AW-1:GRAN_LSB]),
        .wr_attr  (cfg_wdata[2:0]),
        .lk_gran  (up_addr[AW-1:GRAN_LSB]),
        .lk_res   (attrs)
    );

    saf_policy u_policy (
        .core_secure (core_secure),
        .fetch       (up_fetch),
        .attrs       (attrs),
        .deny        (pol_deny),
        .code        (pol_code)
    );

    saf_stack_guard #(
        .AW (AW)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (stk_we),
        .wr_nonsec  (cfg_addr[0]),
        .wr_data    (cfg_wdata),
        .chk_secure (core_secure),
        .chk_value  (sp_value),
        .violation  (sp_viol)
    );

    // Next-state and fault-code selection
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            S_IDLE: begin
                if (cfg_we) begin
                    if (!core_secure) begin
                        state_d = S_ALERT;
                        code_d  = FLT_SECURITY;
                    end
                end else if (sp_valid) begin
                    if (sp_viol) begin
                        state_d = S_ALERT;
                        code_d  = FLT_STACK;
                    end
                end else if (up_valid) begin
                    if (pol_deny) begin
                        state_d = S_DENY;
                        code_d  = pol_code;
                    end else begin
                        state_d = S_ISSUE;
                    end
                end
            end
            S_ISSUE: if (dn_ack) state_d = S_RESP;
            S_RESP:  state_d = S_IDLE;
            S_DENY:  state_d = S_IDLE;
            S_ALERT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            code_q      <= FLT_NONE;
            req_addr_q  <= '0;
            req_write_q <= 1'b0;
            req_fetch_q <= 1'b0;
            req_wdata_q <= '0;
            req_wstrb_q <= '0;
            rdata_q     <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            if (req_take) begin
                req_addr_q  <= up_addr;
                req_write_q <= up_write;
                req_fetch_q <= up_fetch;
                req_wdata_q <= up_wdata;
                req_wstrb_q <= up_wstrb;
            end
            if (state_q == S_ISSUE && dn_ack)
                rdata_q <= req_write_q ? '0 : dn_rdata;
        end
    end

    assign dn_addr  = req_addr_q;
    assign dn_write = req_write_q;
    assign dn_fetch = req_fetch_q;
    assign dn_wdata = req_wdata_q;

    // Outputs decoded from the state
    always_comb begin
        up_ready    = 1'b0;
        up_rvalid   = 1'b0;
        up_rdata    = '0;
        dn_valid    = 1'b0;
        dn_wstrb    = '0;
        fault_valid = 1'b0;
        fault_code  = FLT_NONE;
        unique case (state_q)
            S_IDLE:  up_ready = 1'b1;
            S_ISSUE: begin
                dn_valid = 1'b1;
                dn_wstrb = req_write_q ? req_wstrb_q : '0;
            end
            S_RESP: begin
                up_rvalid = 1'b1;
                up_rdata  = rdata_q;
            end
            S_DENY: begin
                up_rvalid   = 1'b1;
                fault_valid = 1'b1;
                fault_code  = code_q;
            end
            S_ALERT: begin
                fault_valid = 1'b1;
                fault_code  = code_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/saf_checker.sv
`timescale 1ns/1ps
module saf_checker #(
    parameter int AW = 32,
    parameter int DW = 32
)(
    input logic            clk,
    input logic            rst_n,
    input logic            up_ready,
    input logic            up_rvalid,
    input logic [DW-1:0]   up_rdata,
    input logic            dn_valid,
    input logic [AW-1:0]   dn_addr,
    input logic            dn_write,
    input logic [DW/8-1:0] dn_wstrb,
    input logic            dn_ack,
    input logic            fault_valid,
    input logic [1:0]      fault_code
);
    // R7: a refused completion returns zero data
    p_deny_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && up_rvalid) |-> (up_rdata == '0));

    // R7: the fault indication lasts one cycle
    p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid);

    // R3: no downstream activity while a fault is reported
    p_no_fwd_on_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (!dn_valid && dn_wstrb == '0));

    // R4: strobes only accompany a forwarded write
    p_strobe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_wstrb != '0) |-> (dn_valid && dn_write));

    // R4: forwarded request held stable until acknowledged
    p_hold_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ack) |=> (dn_valid && $stable(dn_addr)));

    // R9: fault codes are never zero while signalled
    p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_code != 2'd0));

    // R10: filter returns to accepting after every completion
    p_ready_after_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid |=> up_ready);
endmodule

bind sec_access_filter saf_checker #(
    .AW (AW),
    .DW (DW)
) u_saf_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_ready    (up_ready),
    .up_rvalid   (up_rvalid),
    .up_rdata    (up_rdata),
    .dn_valid    (dn_valid),
    .dn_addr     (dn_addr),
    .dn_write    (dn_write),
    .dn_wstrb    (dn_wstrb),
    .dn_ack      (dn_ack),
    .fault_valid (fault_valid),
    .fault_code  (fault_code)
);

// File: tb/sec_access_filter_tb_top.sv
`timescale 1ns/1ps
module sec_access_filter_tb_top;

    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_secure = 1'b0;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic [31:0] up_addr = '0;
    logic        up_write = 1'b0;
    logic        up_fetch = 1'b0;
    logic [31:0] up_wdata = '0;
    logic [3:0]  up_wstrb = '0;
    logic        up_rvalid;
    logic [31:0] up_rdata;
    logic        dn_valid;
    logic [31:0] dn_addr;
    logic        dn_write;
    logic        dn_fetch;
    logic [31:0] dn_wdata;
    logic [3:0]  dn_wstrb;
    logic        dn_ack = 1'b0;
    logic [31:0] dn_rdata = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        sp_valid = 1'b0;
    logic [31:0] sp_value = '0;
    logic        fault_valid;
    logic [1:0]  fault_code;

    always #4 clk = ~clk;

    sec_access_filter dut_i (
        .clk(clk), .rst_n(rst_n), .core_secure(core_secure),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
        .up_write(up_write), .up_fetch(up_fetch), .up_wdata(up_wdata),
        .up_wstrb(up_wstrb), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_addr(dn_addr), .dn_write(dn_write),
        .dn_fetch(dn_fetch), .dn_wdata(dn_wdata), .dn_wstrb(dn_wstrb),
        .dn_ack(dn_ack), .dn_rdata(dn_rdata), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .sp_valid(sp_valid),
        .sp_value(sp_value), .fault_valid(fault_valid), .fault_code(fault_code)
    );

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          resp;
        logic [31:0] data;
        bit          flt;
        logic [1:0]  code;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    // Bench copy of the configuration, updated from the bench's own writes
    logic [26:0] m_base [NREG];
    logic [26:0] m_lim  [NREG];
    bit          m_en   [NREG];
    bit          m_sec  [NREG];
    bit          m_xo   [NREG];
    logic [31:0] m_sl_s = '0, m_sl_ns = '0;

    logic [31:0] mem    [256];
    logic [31:0] shadow [256];

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            shadow[i] = '0;
        end
        for (int i = 0; i < NREG; i++) begin
            m_base[i] = '0; m_lim[i] = '0;
            m_en[i] = 0; m_sec[i] = 0; m_xo[i] = 0;
        end
    end

    // Downstream memory: acknowledges one cycle after dn_valid
    always @(posedge clk) begin
        dn_ack <= dn_valid && !dn_ack;
        if (dn_valid && !dn_ack) begin
            if (dn_write)
                for (int b = 0; b < 4; b++)
                    if (dn_wstrb[b]) mem[dn_addr[9:2]][8*b +: 8] <= dn_wdata[8*b +: 8];
            dn_rdata <= mem[dn_addr[9:2]];
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Monitor: pops one expectation per response or fault pulse
    always @(negedge clk) begin
        if (rst_n && (up_rvalid || fault_valid)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7", "unexpected output", {30'd0, up_rvalid, fault_valid}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(up_rvalid == e.resp, e.tag, "rvalid", 32'(up_rvalid), 32'(e.resp));
                chk(fault_valid == e.flt, e.tag, "fault_valid", 32'(fault_valid), 32'(e.flt));
                if (e.flt) chk(fault_code == e.code, e.tag, "fault_code", 32'(fault_code), 32'(e.code));
                if (e.resp) chk(up_rdata == e.data, e.tag, "rdata", up_rdata, e.data);
            end
        end
    end

    function automatic void predict(input bit sec, input bit fetch, input logic [31:0] a,
                                    output bit deny, output logic [1:0] code);
        bit msec = 1'b1;
        bit mxo  = 1'b0;
        for (int i = NREG - 1; i >= 0; i--)
            if (m_en[i] && a[31:5] >= m_base[i] && a[31:5] <= m_lim[i]) begin
                msec = m_sec[i];
                mxo  = m_xo[i];
            end
        deny = 1'b0;
        code = 2'd0;
        if (!sec && msec) begin deny = 1'b1; code = 2'd1; end
        else if (mxo && !fetch) begin deny = 1'b1; code = 2'd2; end
    endfunction

    task automatic wait_ready;
        while (!up_ready) @(negedge clk);
    endtask

    task automatic cfg_write(input bit sec, input logic [5:0] a, input logic [31:0] d, input string tag);
        wait_ready();
        if (!sec) begin
            exp_t e;
            e.resp = 0; e.data = '0; e.flt = 1; e.code = 2'd1; e.tag = tag;
            exp_q.push_back(e);
        end else if (!a[5]) begin
            if (a[1:0] == 2'd0) m_base[a[4:2]] = d[31:5];
            if (a[1:0] == 2'd1) m_lim[a[4:2]]  = d[31:5];
            if (a[1:0] == 2'd2) begin
                m_en[a[4:2]] = d[0]; m_sec[a[4:2]] = d[1]; m_xo[a[4:2]] = d[2];
            end
        end else if (a[0]) m_sl_ns = d;
        else m_sl_s = d;
        core_secure = sec; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0;
        if (sec) chk(fault_valid == 0, tag, "no fault on secure cfg", 32'(fault_valid), 32'd0);
    endtask

    task automatic region(input int idx, input int g_lo, input int g_hi, input logic [2:0] attr);
        cfg_write(1, {1'b0, 3'(idx), 2'd0}, 32'(g_lo) << 5, "R8");
        cfg_write(1, {1'b0, 3'(idx), 2'd1}, 32'(g_hi) << 5, "R8");
        cfg_write(1, {1'b0, 3'(idx), 2'd2}, {29'd0, attr}, "R8");
    endtask

    task automatic sp_check(input bit sec, input logic [31:0] v, input string tag);
        bit viol;
        viol = v < (sec ? m_sl_s : m_sl_ns);
        wait_ready();
        if (viol) begin
            exp_t e;
            e.resp = 0; e.data = '0; e.flt = 1; e.code = 2'd3; e.tag = tag;
            exp_q.push_back(e);
        end
        core_secure = sec; sp_valid = 1; sp_value = v;
        @(posedge clk);
        @(negedge clk);
        sp_valid = 0;
        if (!viol) chk(fault_valid == 0, tag, "no stack fault", 32'(fault_valid), 32'd0);
    endtask

    task automatic access(input bit sec, input bit fetch, input bit wr, input logic [31:0] a,
                          input logic [31:0] wd, input logic [3:0] ws, input string tag);
        bit deny;
        logic [1:0] code;
        exp_t e;
        predict(sec, fetch, a, deny, code);
        e.resp = 1; e.flt = deny; e.code = code; e.tag = tag;
        e.data = (deny || wr) ? 32'd0 : shadow[a[9:2]];
        if (!deny && wr)
            for (int b = 0; b < 4; b++)
                if (ws[b]) shadow[a[9:2]][8*b +: 8] = wd[8*b +: 8];
        exp_q.push_back(e);
        wait_ready();
        core_secure = sec; up_valid = 1; up_fetch = fetch; up_write = wr;
        up_addr = a; up_wdata = wd; up_wstrb = ws;
        @(posedge clk);
        @(negedge clk);
        up_valid = 0;
        if (deny) begin
            chk(dn_valid == 0 && dn_wstrb == 0, tag, "no forward on refusal",
                {31'd0, dn_valid}, 32'd0);
            chk(up_rvalid && fault_valid, tag, "refusal timing",
                {30'd0, up_rvalid, fault_valid}, 32'd3);
        end else begin
            chk(dn_valid && dn_addr == a && dn_write == wr && dn_fetch == fetch, tag,
                "forwarded address", dn_addr, a);
            chk(dn_wstrb == (wr ? ws : 4'd0) && (!wr || dn_wdata == wd), tag,
                "forwarded data", dn_wdata, wd);
            @(negedge clk);
            @(negedge clk);
            chk(up_rvalid == 1, "R4", "response cycle", 32'(up_rvalid), 32'd1);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(up_ready == 1, "R1", "up_ready", 32'(up_ready), 32'd1);
        chk(!up_rvalid && !dn_valid && !fault_valid && dn_wstrb == 0, "R1", "idle outputs",
            {28'd0, up_rvalid, dn_valid, fault_valid, |dn_wstrb}, 32'd0);

        // R2: nothing enabled, everything secure
        access(0, 0, 0, 32'h040, 0, 0, "R2");
        access(1, 0, 1, 32'h040, 32'h1111_2222, 4'hF, "R2");
        access(1, 0, 0, 32'h040, 0, 0, "R2");

        // Build the table
        region(0, 0, 7, 3'b001);   // 0x000-0x0FF non-secure
        region(1, 8, 15, 3'b011);  // 0x100-0x1FF secure
        region(2, 16, 19, 3'b101); // 0x200-0x27F non-secure execute-only
        region(3, 4, 7, 3'b011);   // 0x080-0x0FF secure, overlaps slot 0
        region(4, 24, 25, 3'b111); // 0x300-0x33F secure execute-only

        // R4 secure and non-secure traffic to permitted regions
        access(1, 0, 1, 32'h010, 32'hA5A5_1234, 4'hF, "R4");
        access(0, 0, 0, 32'h010, 0, 0, "R4");
        access(0, 0, 1, 32'h014, 32'hDEAD_BEEF, 4'b0011, "R4");
        access(0, 0, 0, 32'h014, 0, 0, "R4");
        access(1, 0, 1, 32'h104, 32'h0BAD_F00D, 4'hF, "R4");
        access(1, 0, 0, 32'h104, 0, 0, "R4");

        // R3 non-secure into secure region
        access(0, 0, 1, 32'h104, 32'h5555_5555, 4'hF, "R3");
        access(0, 0, 0, 32'h104, 0, 0, "R3");
        access(1, 0, 0, 32'h104, 0, 0, "R3");

        // R5 execute-only
        access(1, 0, 1, 32'h200, 32'h1357_9BDF, 4'hF, "R5");
        access(0, 1, 0, 32'h200, 0, 0, "R5");
        access(0, 0, 0, 32'h200, 0, 0, "R5");
        access(1, 0, 0, 32'h200, 0, 0, "R5");
        access(0, 0, 1, 32'h200, 32'hFFFF_FFFF, 4'hF, "R5");
        access(1, 1, 0, 32'h200, 0, 0, "R5");
        access(0, 1, 0, 32'h300, 0, 0, "R5");
        access(1, 1, 0, 32'h300, 0, 0, "R5");

        // R6 overlap: slot 0 wins over slot 3
        access(0, 0, 0, 32'h090, 0, 0, "R6");
        cfg_write(1, {1'b0, 3'd0, 2'd2}, 32'd0, "R6");
        access(0, 0, 0, 32'h090, 0, 0, "R6");

        // R8 non-secure configuration write ignored
        cfg_write(0, {1'b0, 3'd0, 2'd2}, 32'd1, "R8");
        access(0, 0, 0, 32'h090, 0, 0, "R8");
        cfg_write(0, 6'h21, 32'h0000_0100, "R8");
        sp_check(0, 32'h0000_0000, "R8");

        // R9 stack bounds per state
        cfg_write(1, 6'h20, 32'h0000_1000, "R9");
        cfg_write(1, 6'h21, 32'h0000_2000, "R9");
        sp_check(1, 32'h0000_0FFF, "R9");
        sp_check(1, 32'h0000_1000, "R9");
        sp_check(0, 32'h0000_1FFF, "R9");
        sp_check(1, 32'h0000_1FFF, "R9");
        sp_check(0, 32'h0000_2000, "R9");

        // R10 precedence: cfg, then stack, then request
        wait_ready();
        begin
            exp_t e;
            m_en[1] = 1; m_sec[1] = 0; m_xo[1] = 0;
            e.resp = 0; e.data = '0; e.flt = 1; e.code = 2'd3; e.tag = "R10";
            exp_q.push_back(e);
            e.resp = 1; e.data = shadow[32'h104 >> 2]; e.flt = 0; e.code = 2'd0; e.tag = "R10";
            exp_q.push_back(e);
        end
        core_secure = 1; cfg_we = 1; cfg_addr = {1'b0, 3'd1, 2'd2}; cfg_wdata = 32'd1;
        sp_valid = 1; sp_value = 32'h0000_0010;
        up_valid = 1; up_write = 0; up_fetch = 0; up_addr = 32'h104;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0; core_secure = 0;
        chk(up_ready == 1 && !dn_valid, "R10", "cfg taken first", {31'd0, dn_valid}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        sp_valid = 0;
        chk(fault_valid && !dn_valid, "R10", "stack check second", 32'(fault_valid), 32'd1);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        up_valid = 0;
        chk(dn_valid && dn_addr == 32'h104, "R10", "request last", dn_addr, 32'h104);

        for (int k = 0; k < 20 && exp_q.size() != 0; k++) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "pending expectations", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule